// File: doc/BRIEF.md
# Configurable-Mode SPI Master Controller

The block is a full-duplex serial master. It moves one frame out on `mosi_o`, most significant bit first, and captures one frame from `miso_i` at the same time. Software sets the serial-clock idle level and the phase, chooses an 8-bit or a 16-bit frame, and picks a power-of-two divider from the system clock. It can also take direct control of the select line instead of leaving it to the hardware sequencer. A transmit holding buffer and a receive holding buffer sit behind a small word-wide register port. Each buffer has a flag and a maskable interrupt.

To start a frame, software writes a word to the data register. When the engine is idle, it moves the word into its shift register and frees the transmit buffer. It lowers the select line, runs twice the frame length of clock edges, and raises the select line again. The captured word lands in the receive buffer. Reading that word clears the receive flag. A receive-only transfer still needs a dummy write.

Top module: `spi_master_ctl`

## Requirements
- R1: After reset, status (address 2) reads 0x0001: bit 0 (transmit empty) = 1, bit 1 (receive full) = 0, bit 2 (busy) = 0. Also after reset, `nss_o` = 1, `sclk_o` = 0, and both interrupt outputs are 0.
- R2: Control bit 0 (address 0) sets the clock idle level. `sclk_o` equals this bit while no frame runs, and it returns to this level after every frame.
- R3: With control bit 1 = 1, each data bit is launched on the first clock edge of its bit period and captured on the second edge.
- R4: With control bit 1 = 0, the first bit is valid before the first clock edge. Each bit is captured on the first edge of its bit period and changed on the second edge.
- R5: Control bits 5:3 hold a divider code b. Every half clock period lasts 2^b system cycles, so the serial clock runs at the system clock divided by 2^(b+1). The select line falls one half period before the first edge and rises one half period after the last edge.
- R6: Control bit 2 selects a 16-bit frame (1) or an 8-bit frame (0). A frame produces exactly 32 or 16 clock edges. In 8-bit mode only data bits 7:0 are sent and received.
- R7: Data is sent MSB first. A write to address 1 queues the transmit word. A read of address 1 returns the word captured during the same frame, zero-extended.
- R8: When control bit 6 = 1, `nss_o` follows control bit 7 and ignores the frame sequencer. When control bit 6 = 0, the sequencer drives `nss_o`.
- R9: The transmit interrupt equals control bit 8 AND transmit-empty. The receive interrupt equals control bit 9 AND receive-full. Receive-full is set when a frame ends and cleared by a read of address 1.
- R10: Status bit 2 is 1 from the start of a frame until its last bit is sampled. It is 0 otherwise.
- R11: A write to control bits 5:0 while a frame runs does not change that frame's polarity, phase, length or timing. The new values apply from the next frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_addr_i | input | 2 | Register address: 0 control, 1 data, 2 status |
| reg_wdata_i | input | 16 | Write data |
| reg_we_i | input | 1 | Write strobe |
| reg_re_i | input | 1 | Read strobe; a read of address 1 clears receive-full |
| reg_rdata_o | output | 16 | Read data for the addressed register, combinational |
| sclk_o | output | 1 | Serial clock |
| mosi_o | output | 1 | Serial data to the slave |
| miso_i | input | 1 | Serial data from the slave |
| nss_o | output | 1 | Slave select, active low |
| irq_txe_o | output | 1 | Transmit buffer empty interrupt |
| irq_rxf_o | output | 1 | Receive buffer full interrupt |

## Verification
A wrong edge counter or a wrong frame-length latch shows up within the same frame. The select line would then frame too many or too few clock edges, and a bench slave that counts edges sees the difference when the select line rises. A wrong sample or launch parity swaps bit pairs, or slips the frame by one bit. The bench sees this as a data miscompare on the slave side or in the receive buffer when the frame ends. A divider fault changes the number of system cycles between the select fall and the first edge, and that count is measured on every frame. Flag faults appear one cycle after the write or read that should have moved them.

// File: rtl/spi_master_pkg.sv
package spi_master_pkg;
  localparam int unsigned BAUD_W = 3;
  localparam int unsigned MAX_W  = 16;
  localparam int unsigned MIN_W  = 8;
  localparam int unsigned DIV_W  = (1 << BAUD_W) - 1;
  localparam int unsigned EDGE_W = $clog2(2 * MAX_W);

  localparam logic [1:0] ADDR_CTRL = 2'd0;
  localparam logic [1:0] ADDR_DATA = 2'd1;
  localparam logic [1:0] ADDR_STAT = 2'd2;

  typedef struct packed {
    logic              cpol;
    logic              cpha;
    logic              wide;
    logic [BAUD_W-1:0] baud;
  } spi_cfg_t;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_SETUP,
    ST_SHIFT,
    ST_HOLD
  } spi_state_e;
endpackage

// File: rtl/spi_baud_div.sv
module spi_baud_div #(
  parameter int unsigned SEL_W = 3,
  parameter int unsigned CNT_W = (1 << SEL_W) - 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic             tick_o
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] lim;

  // 2^sel - 1; the wrap at the top code yields all ones
  assign lim    = (CNT_W'(1) << sel_i) - CNT_W'(1);
  assign tick_o = run_i && (cnt_q == lim);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (!run_i || tick_o) cnt_q <= '0;
    else                      cnt_q <= cnt_q + CNT_W'(1);
  end

  assert_count_step_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && !tick_o) |=> (!run_i || cnt_q == CNT_W'($past(cnt_q) + CNT_W'(1))));
endmodule

// File: rtl/spi_shift_eng.sv
module spi_shift_eng
  import spi_master_pkg::*;
#(
  parameter int unsigned LONG_W  = MAX_W,
  parameter int unsigned SHORT_W = MIN_W,
  parameter int unsigned CNT_W   = EDGE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  spi_cfg_t          cfg_i,
  input  logic              start_i,
  input  logic [LONG_W-1:0] tx_word_i,
  input  logic              miso_i,
  input  logic              tick_i,
  output logic              pop_o,
  output logic              run_o,
  output logic              busy_o,
  output logic [BAUD_W-1:0] baud_o,
  output logic              sclk_o,
  output logic              mosi_o,
  output logic              nss_o,
  output logic              rx_push_o,
  output logic [LONG_W-1:0] rx_word_o
);
  spi_state_e        state_q;
  spi_cfg_t          cfg_q;
  logic [LONG_W-1:0] tx_sr_q, rx_sr_q, rx_next;
  logic [CNT_W-1:0]  edge_q, last_edge;
  logic              ph_q;
  logic              edge_ev, lead, samp, drive;

  assign last_edge = cfg_q.wide ? CNT_W'(2 * LONG_W - 1) : CNT_W'(2 * SHORT_W - 1);
  assign edge_ev   = tick_i && (state_q == ST_SETUP || state_q == ST_SHIFT);
  assign lead      = ~edge_q[0];
  assign samp      = lead ^ cfg_q.cpha;
  // with cpha=1 the MSB is already on the line at edge 0
  assign drive     = !samp && !(cfg_q.cpha && edge_q == '0);
  assign rx_next   = {rx_sr_q[LONG_W-2:0], miso_i};

  assign pop_o     = (state_q == ST_IDLE) && start_i;
  assign run_o     = (state_q != ST_IDLE);
  assign busy_o    = (state_q == ST_SETUP) || (state_q == ST_SHIFT);
  assign baud_o    = cfg_q.baud;
  assign nss_o     = (state_q == ST_IDLE);
  assign sclk_o    = (state_q == ST_IDLE) ? cfg_i.cpol : (cfg_q.cpol ^ ph_q);
  assign mosi_o    = cfg_q.wide ? tx_sr_q[LONG_W-1] : tx_sr_q[SHORT_W-1];
  assign rx_push_o = edge_ev && (edge_q == last_edge);
  assign rx_word_o = samp ? rx_next : rx_sr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cfg_q   <= '0;
      tx_sr_q <= '0;
      rx_sr_q <= '0;
      edge_q  <= '0;
      ph_q    <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          ph_q   <= 1'b0;
          edge_q <= '0;
          if (start_i) begin
            cfg_q   <= cfg_i;
            tx_sr_q <= tx_word_i;
            rx_sr_q <= '0;
            state_q <= ST_SETUP;
          end
        end
        ST_SETUP, ST_SHIFT: begin
          if (edge_ev) begin
            ph_q   <= ~ph_q;
            edge_q <= edge_q + CNT_W'(1);
            if (samp)  rx_sr_q <= rx_next;
            if (drive) tx_sr_q <= {tx_sr_q[LONG_W-2:0], 1'b0};
            if (edge_q == last_edge) state_q <= ST_HOLD;
            else                     state_q <= ST_SHIFT;
          end
        end
        ST_HOLD: if (tick_i) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assert_cfg_frozen_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_o && $past(run_o)) |-> $stable(cfg_q));
  assert_edge_bound_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_SHIFT) |-> (edge_q <= last_edge));
  assert_idle_level_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_HOLD) |-> (ph_q == 1'b0));
  assert_push_then_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_push_o |=> (state_q == ST_HOLD && !busy_o));
endmodule

// File: rtl/spi_reg_file.sv
module spi_reg_file
  import spi_master_pkg::*;
#(
  parameter int unsigned ADDR_W = 2,
  parameter int unsigned REG_W  = 16,
  parameter int unsigned DATA_W = MAX_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [REG_W-1:0]  wdata_i,
  input  logic              we_i,
  input  logic              re_i,
  output logic [REG_W-1:0]  rdata_o,
  input  logic              pop_i,
  input  logic              push_i,
  input  logic [DATA_W-1:0] rx_word_i,
  input  logic              busy_i,
  output spi_cfg_t          cfg_o,
  output logic              tx_full_o,
  output logic [DATA_W-1:0] tx_word_o,
  output logic              sw_en_o,
  output logic              sw_lvl_o,
  output logic              irq_txe_o,
  output logic              irq_rxf_o
);
  localparam int unsigned CTRL_W = 7 + BAUD_W;
  localparam int unsigned B_SWEN = 3 + BAUD_W;

  logic [CTRL_W-1:0] ctrl_q;
  logic [DATA_W-1:0] tx_buf_q, rx_buf_q;
  logic              tx_full_q, rx_full_q;
  logic              wr_ctrl, wr_data, rd_data;

  assign wr_ctrl = we_i && (addr_i == ADDR_W'(ADDR_CTRL));
  assign wr_data = we_i && (addr_i == ADDR_W'(ADDR_DATA));
  assign rd_data = re_i && (addr_i == ADDR_W'(ADDR_DATA));

  assign cfg_o.cpol = ctrl_q[0];
  assign cfg_o.cpha = ctrl_q[1];
  assign cfg_o.wide = ctrl_q[2];
  assign cfg_o.baud = ctrl_q[3 +: BAUD_W];
  assign sw_en_o    = ctrl_q[B_SWEN];
  assign sw_lvl_o   = ctrl_q[B_SWEN+1];
  assign irq_txe_o  = ctrl_q[B_SWEN+2] & ~tx_full_q;
  assign irq_rxf_o  = ctrl_q[B_SWEN+3] & rx_full_q;
  assign tx_full_o  = tx_full_q;
  assign tx_word_o  = tx_buf_q;

  always_comb begin
    unique case (addr_i)
      ADDR_W'(ADDR_CTRL): rdata_o = REG_W'(ctrl_q);
      ADDR_W'(ADDR_DATA): rdata_o = REG_W'(rx_buf_q);
      ADDR_W'(ADDR_STAT): rdata_o = REG_W'({busy_i, rx_full_q, ~tx_full_q});
      default:            rdata_o = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q    <= '0;
      tx_buf_q  <= '0;
      rx_buf_q  <= '0;
      tx_full_q <= 1'b0;
      rx_full_q <= 1'b0;
    end else begin
      if (wr_ctrl) ctrl_q <= wdata_i[CTRL_W-1:0];
      if (wr_data) tx_buf_q <= wdata_i[DATA_W-1:0];
      tx_full_q <= (tx_full_q & ~pop_i) | wr_data;
      if (push_i) rx_buf_q <= rx_word_i;
      rx_full_q <= push_i | (rx_full_q & ~rd_data);
    end
  end

  assert_rx_flag_set_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |=> rx_full_q);
  assert_pop_only_full_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |-> tx_full_q);
endmodule

// File: rtl/spi_master_ctl.sv
module spi_master_ctl
  import spi_master_pkg::*;
#(
  parameter int unsigned ADDR_W = 2,
  parameter int unsigned REG_W  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [REG_W-1:0]  reg_wdata_i,
  input  logic              reg_we_i,
  input  logic              reg_re_i,
  output logic [REG_W-1:0]  reg_rdata_o,
  output logic              sclk_o,
  output logic              mosi_o,
  input  logic              miso_i,
  output logic              nss_o,
  output logic              irq_txe_o,
  output logic              irq_rxf_o
);
  spi_cfg_t          cfg;
  logic              tx_full, pop, push, busy, run, tick, sw_en, sw_lvl, hw_nss;
  logic [MAX_W-1:0]  tx_word, rx_word;
  logic [BAUD_W-1:0] baud;

  spi_reg_file #(.ADDR_W(ADDR_W), .REG_W(REG_W), .DATA_W(MAX_W)) u_regs (
    .clk_i, .rst_ni,
    .addr_i(reg_addr_i), .wdata_i(reg_wdata_i), .we_i(reg_we_i), .re_i(reg_re_i),
    .rdata_o(reg_rdata_o),
    .pop_i(pop), .push_i(push), .rx_word_i(rx_word), .busy_i(busy),
    .cfg_o(cfg), .tx_full_o(tx_full), .tx_word_o(tx_word),
    .sw_en_o(sw_en), .sw_lvl_o(sw_lvl), .irq_txe_o, .irq_rxf_o
  );

  spi_baud_div #(.SEL_W(BAUD_W), .CNT_W(DIV_W)) u_div (
    .clk_i, .rst_ni, .run_i(run), .sel_i(baud), .tick_o(tick)
  );

  spi_shift_eng #(.LONG_W(MAX_W), .SHORT_W(MIN_W), .CNT_W(EDGE_W)) u_eng (
    .clk_i, .rst_ni, .cfg_i(cfg), .start_i(tx_full), .tx_word_i(tx_word),
    .miso_i, .tick_i(tick), .pop_o(pop), .run_o(run), .busy_o(busy), .baud_o(baud),
    .sclk_o, .mosi_o, .nss_o(hw_nss), .rx_push_o(push), .rx_word_o(rx_word)
  );

  assign nss_o = sw_en ? sw_lvl : hw_nss;

  assert_sclk_quiet_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hw_nss && $past(hw_nss) && $stable(cfg.cpol)) |-> $stable(sclk_o));
endmodule

// File: tb/spi_master_ctl_bench.sv
module spi_master_ctl_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [1:0]  reg_addr_i = '0;
  logic [15:0] reg_wdata_i = '0;
  logic        reg_we_i = 1'b0, reg_re_i = 1'b0;
  logic [15:0] reg_rdata_o;
  logic        sclk_o, mosi_o, nss_o, irq_txe_o, irq_rxf_o;
  logic        miso_i = 1'b0;

  int n_chk = 0, n_fail = 0, cyc = 0;
  bit finished = 0;

  spi_master_ctl u_spi_master_ctl (.*);

  always #(CLK_PERIOD/2) clk_i = ~clk_i;
  always @(posedge clk_i) cyc <= cyc + 1;

  // bench slave model
  bit          tb_cpha = 0;
  int          tb_w = 8;
  logic [15:0] slave_word = '0;
  logic [15:0] s_rx = '0;
  int          s_idx = 0, s_edges = 0, s_frames = 0;
  int          t_fall = 0, t_first = 0, t_last = 0, t_rise = 0;
  logic        p_nss = 1'bx, p_sclk = 1'bx;

  always @(nss_o or sclk_o) begin
    if (nss_o !== p_nss) begin
      if (nss_o === 1'b0) begin
        s_edges = 0; s_rx = '0; t_fall = cyc;
        if (!tb_cpha) begin miso_i = slave_word[tb_w-1]; s_idx = tb_w - 2; end
        else s_idx = tb_w - 1;
      end else if (nss_o === 1'b1 && p_nss === 1'b0) begin
        t_rise = cyc; s_frames++;
      end
      p_nss = nss_o;
    end
    if (sclk_o !== p_sclk) begin
      if (nss_o === 1'b0) begin
        if (s_edges == 0) t_first = cyc;
        t_last = cyc;
        if (((s_edges % 2) == 0) ^ tb_cpha) s_rx = {s_rx[14:0], mosi_o};
        else if (s_idx >= 0) begin miso_i = slave_word[s_idx]; s_idx--; end
        s_edges++;
      end
      p_sclk = sclk_o;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic reg_wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk_i); reg_addr_i = a; reg_wdata_i = d; reg_we_i = 1'b1;
    @(negedge clk_i); reg_we_i = 1'b0;
  endtask

  task automatic reg_rd(input logic [1:0] a, output logic [15:0] d);
    @(negedge clk_i); reg_addr_i = a; reg_re_i = 1'b1;
    #1 d = reg_rdata_o;
    @(negedge clk_i); reg_re_i = 1'b0;
  endtask

  function automatic logic [15:0] ctrl_word(input bit cpol, cpha, wide, input logic [2:0] b);
    return {10'b0, b, wide, cpha, cpol};
  endfunction

  task automatic wait_frame(input int f0);
    int i;
    for (i = 0; i < 20000; i++) begin
      @(posedge clk_i);
      if (s_frames > f0) break;
    end
    if (i >= 20000) chk("R7 frame timeout", 0, 1);
    @(negedge clk_i);
  endtask

  task automatic run_frame(input bit cpol, cpha, wide, input logic [2:0] b,
                           input logic [15:0] mtx, stx, output logic [15:0] mrx);
    int f0;
    reg_wr(2'd0, ctrl_word(cpol, cpha, wide, b));
    tb_cpha = cpha; tb_w = wide ? 16 : 8; slave_word = stx;
    f0 = s_frames;
    reg_wr(2'd1, mtx);
    wait_frame(f0);
    reg_rd(2'd1, mrx);
  endtask

  task automatic t_reset;
    logic [15:0] d;
    reg_rd(2'd2, d);
    chk("R1 status", d, 16'h0001);
    chk("R1 nss", nss_o, 1'b1);
    chk("R1 sclk", sclk_o, 1'b0);
    chk("R1 irq", {irq_txe_o, irq_rxf_o}, 2'b00);
  endtask

  task automatic t_modes;
    logic [15:0] mrx, mtx, stx, msk;
    for (int m = 0; m < 4; m++) begin
      for (int w = 0; w < 2; w++) begin
        mtx = 16'hA5C3 ^ 16'(m * 16'h1357) ^ 16'(w * 16'h0F0F);
        stx = 16'h3C96 ^ 16'(m * 16'h2461) ^ 16'(w * 16'hF00F);
        msk = w ? 16'hFFFF : 16'h00FF;
        run_frame(m[0], m[1], w[0], 3'd1, mtx, stx, mrx);
        chk(m[1] ? "R3 slave rx" : "R4 slave rx", s_rx & msk, mtx & msk);
        chk("R7 master rx", mrx, stx & msk);
        chk("R6 edge count", s_edges, w ? 32 : 16);
        chk("R2 idle level", sclk_o, m[0]);
      end
    end
  endtask

  task automatic t_baud;
    logic [15:0] mrx;
    for (int b = 0; b < 8; b += 3) begin
      run_frame(1'b0, 1'b1, 1'b0, 3'(b), 16'h005A, 16'h00C3, mrx);
      chk("R5 lead half", t_first - t_fall, 1 << b);
      chk("R5 trail half", t_rise - t_last, 1 << b);
      chk("R5 edge span", t_last - t_first, 15 * (1 << b));
      chk("R5 data", mrx, 16'h00C3);
    end
  endtask

  task automatic t_flags;
    logic [15:0] d;
    int f0;
    reg_wr(2'd0, 16'h0300 | ctrl_word(0, 0, 0, 3'd2));
    tb_cpha = 0; tb_w = 8; slave_word = 16'h0081;
    chk("R9 txe irq idle", irq_txe_o, 1'b1);
    f0 = s_frames;
    reg_wr(2'd1, 16'h0042);
    chk("R9 txe irq after write", irq_txe_o, 1'b0);
    repeat (3) @(negedge clk_i);
    chk("R9 txe irq after load", irq_txe_o, 1'b1);
    reg_rd(2'd2, d);
    chk("R10 busy mid frame", d[2], 1'b1);
    wait_frame(f0);
    reg_rd(2'd2, d);
    chk("R10 busy after frame", d[2], 1'b0);
    chk("R9 rx full flag", d[1], 1'b1);
    chk("R9 rxf irq", irq_rxf_o, 1'b1);
    reg_rd(2'd1, d);
    chk("R7 rx data", d, 16'h0081);
    chk("R9 rxf irq cleared", irq_rxf_o, 1'b0);
    reg_rd(2'd2, d);
    chk("R9 rx full cleared", d[1], 1'b0);
  endtask

  task automatic t_sw_select;
    logic [15:0] mrx;
    int lows = 0;
    reg_wr(2'd0, 16'h0040);
    chk("R8 sw select low", nss_o, 1'b0);
    reg_wr(2'd0, 16'h00C0);
    chk("R8 sw select high", nss_o, 1'b1);
    tb_cpha = 0; tb_w = 8; slave_word = 16'h0011;
    reg_wr(2'd1, 16'h0022);
    for (int i = 0; i < 40; i++) begin
      @(negedge clk_i);
      if (nss_o !== 1'b1) lows++;
    end
    chk("R8 override holds during frame", lows, 0);
    reg_rd(2'd1, mrx);
    reg_wr(2'd0, 16'h0000);
    chk("R8 hw select idle", nss_o, 1'b1);
  endtask

  task automatic t_cfg_change;
    logic [15:0] mrx;
    int f0;
    reg_wr(2'd0, ctrl_word(0, 0, 0, 3'd1));
    tb_cpha = 0; tb_w = 8; slave_word = 16'h00B4;
    f0 = s_frames;
    reg_wr(2'd1, 16'h0069);
    repeat (4) @(negedge clk_i);
    reg_wr(2'd0, ctrl_word(1, 1, 1, 3'd0));
    wait_frame(f0);
    reg_rd(2'd1, mrx);
    chk("R11 edge count", s_edges, 16);
    chk("R11 lead half", t_first - t_fall, 2);
    chk("R11 slave rx", s_rx & 16'h00FF, 16'h0069);
    chk("R11 master rx", mrx, 16'h00B4);
    chk("R11 new idle level", sclk_o, 1'b1);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog actual=running expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_modes();
    t_baud();
    t_flags();
    t_sw_select();
    t_cfg_change();
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule